// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block sits behind the instruction decoder of a 16-bit processor. For each branch-class operation it is handed a condition selector, an 8-bit signed word displacement, the four condition flags (negative, zero, overflow, carry), the already-advanced program counter and, for the counted-loop operation, the value of the selected register. One cycle later it reports whether control transfers and the byte address it transfers to.

It covers the unconditional branch, the single-flag tests, the signed tests after a compare, and the unsigned tests after a compare. It also covers a loop operation. The loop operation decrements a register, writes the result back and branches backwards while the result is non-zero. The fetch unit consumes `taken_o`/`target_o`. The register file consumes `reg_we_o`/`reg_o`.

Top module: `branch_decide`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `taken_o`, `target_o`, `reg_o` and `reg_we_o` are all zero.
- R2: Every result appears exactly one clock after `valid_i` is high. `valid_o` is high in the cycle after `valid_i` was high and low otherwise.
- R3: Selector codes and taken conditions: 0 always; 1 when Z=0; 2 when Z=1; 3 when N=0; 4 when N=1; 5 when V=0; 6 when V=1; 7 when C=0; 8 when C=1. `flags_i` is {N,Z,V,C} with N in bit 3 and C in bit 0.
- R4: Signed tests after a compare a-b: code 9 (a>=b) is taken when N^V=0; code 10 (a<b) when N^V=1; code 11 (a>b) when Z|(N^V)=0; code 12 (a<=b) when Z|(N^V)=1.
- R5: Unsigned tests after a compare a-b: code 13 (higher) is taken when C=0 and Z=0; code 14 (lower or same) when C|Z=1; code 15 (higher or same) when C=0; code 16 (lower) when C=1.
- R6: For codes 0 to 16, `target_o` is `pc_i` plus twice the sign-extended `offset_i`, modulo 2^16.
- R7: Code 17 is the counted loop. `reg_o` is `reg_i`-1 modulo 2^16 and `reg_we_o` is 1. `taken_o` is 1 exactly when that result is non-zero. `target_o` is `pc_i` minus twice `offset_i[5:0]`, and `offset_i[7:6]` is ignored.
- R8: Codes 18 to 255 are never taken and never assert `reg_we_o`.
- R9: A cycle with `valid_i` low leaves `taken_o`, `target_o`, `reg_o` and `reg_we_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| cond_i | input | 8 | Condition selector code |
| offset_i | input | 8 | Signed word displacement (6-bit backward count for the loop) |
| flags_i | input | 4 | {N,Z,V,C} |
| pc_i | input | 16 | Advanced program counter |
| reg_i | input | 16 | Loop register value |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Branch target byte address |
| reg_o | output | 16 | Decremented loop register |
| reg_we_o | output | 1 | Loop register write enable |

## Verification
The loop operation produces a register write-back and a branch decision in the same cycle. Both come from the same decremented value. The bench drives the loop code with register values 1, 0, 2 and 0x8000. It checks that a result of zero clears `taken_o` while still writing the register, and that zero wraps to 0xFFFF and branches. Each signed and unsigned test is also judged against an integer comparison of the compared operands, with the flags derived from their 8-bit difference.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [CODE_W-1:0] {
    BC_ALW = 8'd0,  BC_ZC  = 8'd1,  BC_ZS  = 8'd2,  BC_NC  = 8'd3,
    BC_NS  = 8'd4,  BC_VC  = 8'd5,  BC_VS  = 8'd6,  BC_CC  = 8'd7,
    BC_CS  = 8'd8,  BC_SGE = 8'd9,  BC_SLT = 8'd10, BC_SGT = 8'd11,
    BC_SLE = 8'd12, BC_UHI = 8'd13, BC_ULS = 8'd14, BC_UHS = 8'd15,
    BC_ULO = 8'd16, BC_LOOP = 8'd17
  } bcode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic logic code_known(input logic [CODE_W-1:0] code);
    return code <= 8'(BC_LOOP);
  endfunction
endpackage

// File: rtl/bd_cond_eval.sv
module bd_cond_eval
  import bd_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  flags_t            fl,
  output logic              hit
);
  logic lt_s;
  assign lt_s = fl.n ^ fl.v;

  always_comb begin
    case (code)
      8'(BC_ALW): hit = 1'b1;
      8'(BC_ZC):  hit = ~fl.z;
      8'(BC_ZS):  hit = fl.z;
      8'(BC_NC):  hit = ~fl.n;
      8'(BC_NS):  hit = fl.n;
      8'(BC_VC):  hit = ~fl.v;
      8'(BC_VS):  hit = fl.v;
      8'(BC_CC):  hit = ~fl.c;
      8'(BC_CS):  hit = fl.c;
      8'(BC_SGE): hit = ~lt_s;
      8'(BC_SLT): hit = lt_s;
      8'(BC_SGT): hit = ~(fl.z | lt_s);
      8'(BC_SLE): hit = fl.z | lt_s;
      8'(BC_UHI): hit = ~(fl.c | fl.z);
      8'(BC_ULS): hit = fl.c | fl.z;
      8'(BC_UHS): hit = ~fl.c;
      8'(BC_ULO): hit = fl.c;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bd_target.sv
module bd_target #(
  parameter int AW     = 16,
  parameter int OFF_W  = 8,
  parameter int LOOP_W = 6
) (
  input  logic [AW-1:0]    pc,
  input  logic [OFF_W-1:0] off,
  input  logic             is_loop,
  output logic [AW-1:0]    target
);
  localparam int FPAD = AW - OFF_W - 1;
  localparam int BPAD = AW - LOOP_W - 1;

  logic [AW-1:0] fwd_bytes;
  logic [AW-1:0] back_bytes;

  assign fwd_bytes  = {{FPAD{off[OFF_W-1]}}, off, 1'b0};
  assign back_bytes = {{BPAD{1'b0}}, off[LOOP_W-1:0], 1'b0};

  always_comb begin
    if (is_loop) target = pc - back_bytes;
    else         target = pc + fwd_bytes;
  end
endmodule

// File: rtl/bd_loop_dec.sv
module bd_loop_dec #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] value,
  output logic [DW-1:0] dec,
  output logic          nonzero
);
  assign dec     = value - DW'(1);
  assign nonzero = |dec;
endmodule

// File: rtl/branch_decide.sv
module branch_decide
  import bd_pkg::*;
#(
  parameter int AW     = 16,
  parameter int OFF_W  = 8,
  parameter int LOOP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [7:0]       cond_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [3:0]       flags_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    reg_i,
  output logic             valid_o,
  output logic             taken_o,
  output logic [AW-1:0]    target_o,
  output logic [AW-1:0]    reg_o,
  output logic             reg_we_o
);
  flags_t        fl;
  logic          is_loop;
  logic          flag_hit;
  logic          loop_nz;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] tgt_d;
  logic          taken_d;
  logic [AW-1:0] reg_d;

  assign fl      = flags_t'(flags_i);
  assign is_loop = (cond_i == 8'(BC_LOOP));

  bd_cond_eval u_cond (.code(cond_i), .fl(fl), .hit(flag_hit));

  bd_target #(.AW(AW), .OFF_W(OFF_W), .LOOP_W(LOOP_W)) u_tgt (
    .pc(pc_i), .off(offset_i), .is_loop(is_loop), .target(tgt_d)
  );

  bd_loop_dec #(.DW(AW)) u_dec (.value(reg_i), .dec(dec_val), .nonzero(loop_nz));

  always_comb begin
    taken_d = is_loop ? loop_nz : flag_hit;
    reg_d   = is_loop ? dec_val : reg_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      target_o <= '0;
      reg_o    <= '0;
      reg_we_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o  <= taken_d;
        target_o <= tgt_d;
        reg_o    <= reg_d;
        reg_we_o <= is_loop;
      end
    end
  end

  AST_RESULT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o); // R2
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 8'(BC_ALW)) |=> taken_o); // R3
  AST_SIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 8'(BC_SLT)) |=> (taken_o == $past(flags_i[3] ^ flags_i[1]))); // R4
  AST_UNSIGNED_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cond_i == 8'(BC_ULO)) |=> (taken_o == $past(flags_i[0]))); // R5
  AST_LOOP_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (taken_o == (reg_o != '0))); // R7
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !code_known(cond_i)) |=> (!taken_o && !reg_we_o)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(target_o) && $stable(taken_o) && $stable(reg_o))); // R9
endmodule

// File: tb/tb_branch_decide.sv
module tb_branch_decide;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [7:0]  cond_i;
  logic [7:0]  offset_i;
  logic [3:0]  flags_i;
  logic [15:0] pc_i;
  logic [15:0] reg_i;
  logic        valid_o;
  logic        taken_o;
  logic [15:0] target_o;
  logic [15:0] reg_o;
  logic        reg_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  branch_decide dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_i(cond_i),
    .offset_i(offset_i), .flags_i(flags_i), .pc_i(pc_i), .reg_i(reg_i),
    .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o),
    .reg_o(reg_o), .reg_we_o(reg_we_o)
  );

  // compare operand pairs {a,b}
  localparam logic [15:0] PAIRS [12] = '{
    16'h0000, 16'h0101, 16'h0201, 16'h0102, 16'h7F80, 16'h807F,
    16'hFF01, 16'h01FF, 16'h8080, 16'hFE7F, 16'h7FFF, 16'h8001
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cmp_flags(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    r = a - b;
    return {r[7], r == 8'd0, (a[7] != b[7]) && (r[7] != a[7]), a < b};
  endfunction

  function automatic logic ref_cmp(input int code, input logic [7:0] a, input logic [7:0] b);
    int sa, sb, ua, ub;
    sa = int'($signed(a)); sb = int'($signed(b)); ua = int'(a); ub = int'(b);
    case (code)
      9:  return sa >= sb;
      10: return sa <  sb;
      11: return sa >  sb;
      12: return sa <= sb;
      13: return ua >  ub;
      14: return ua <= ub;
      15: return ua >= ub;
      default: return ua < ub;
    endcase
  endfunction

  function automatic logic ref_flag(input int code, input logic [3:0] f);
    case (code)
      0: return 1'b1;
      1: return ~f[2];
      2: return f[2];
      3: return ~f[3];
      4: return f[3];
      5: return ~f[1];
      6: return f[1];
      7: return ~f[0];
      default: return f[0];
    endcase
  endfunction

  task automatic issue(input logic [7:0] c, input logic [7:0] off, input logic [3:0] f,
                       input logic [15:0] pc, input logic [15:0] rv);
    @(negedge clk);
    valid_i = 1'b1; cond_i = c; offset_i = off; flags_i = f; pc_i = pc; reg_i = rv;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; cond_i = 8'd0; offset_i = 8'd0;
    flags_i = 4'd0; pc_i = 16'd0; reg_i = 16'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {valid_o, taken_o, reg_we_o, target_o[12:0]}, 32'd0);
    chk("R1", {16'd0, reg_o}, 32'd0);
    rst_n = 1'b1;

    // R3 simple conditions over all flag combinations
    for (int c = 0; c <= 8; c++)
      for (int f = 0; f < 16; f++) begin
        issue(8'(c), 8'h04, 4'(f), 16'h1000, 16'h0);
        chk("R3", {31'd0, taken_o}, {31'd0, ref_flag(c, 4'(f))});
      end

    // R4 R5 signed and unsigned tests against integer comparison
    for (int p = 0; p < 12; p++)
      for (int c = 9; c <= 16; c++) begin
        issue(8'(c), 8'h10, cmp_flags(PAIRS[p][15:8], PAIRS[p][7:0]), 16'h2000, 16'h0);
        chk(c <= 12 ? "R4" : "R5", {31'd0, taken_o},
            {31'd0, ref_cmp(c, PAIRS[p][15:8], PAIRS[p][7:0])});
      end

    // R2 latency and R6 target
    issue(8'd0, 8'h7F, 4'd0, 16'h1234, 16'h0);
    chk("R2", {31'd0, valid_o}, 32'd1);
    chk("R6", {16'd0, target_o}, 32'h1332);
    issue(8'd0, 8'h80, 4'd0, 16'h1234, 16'h0);
    chk("R6", {16'd0, target_o}, 32'h1134);
    issue(8'd0, 8'hFF, 4'd0, 16'h0000, 16'h0);
    chk("R6", {16'd0, target_o}, 32'hFFFE);
    chk("R6", {31'd0, reg_we_o}, 32'd0);

    // R7 loop: decrement and branch in the same cycle
    issue(8'd17, 8'hC3, 4'hF, 16'h0400, 16'h0001);
    chk("R7", {31'd0, taken_o}, 32'd0);
    chk("R7", {16'd0, reg_o}, 32'd0);
    chk("R7", {31'd0, reg_we_o}, 32'd1);
    chk("R7", {16'd0, target_o}, 32'h03FA);
    issue(8'd17, 8'h3F, 4'h0, 16'h0100, 16'h0000);
    chk("R7", {31'd0, taken_o}, 32'd1);
    chk("R7", {16'd0, reg_o}, 32'hFFFF);
    chk("R7", {16'd0, target_o}, 32'h0082);
    issue(8'd17, 8'h01, 4'h0, 16'h0100, 16'h0002);
    chk("R7", {15'd0, taken_o, reg_o}, 32'h10001);
    issue(8'd17, 8'h00, 4'h0, 16'h0100, 16'h8000);
    chk("R7", {15'd0, taken_o, reg_o}, 32'h17FFF);
    chk("R7", {16'd0, target_o}, 32'h0100);

    // R8 undefined codes
    issue(8'd18, 8'h02, 4'hF, 16'h0300, 16'h0005);
    chk("R8", {30'd0, taken_o, reg_we_o}, 32'd0);
    issue(8'hFF, 8'h02, 4'h0, 16'h0300, 16'h0005);
    chk("R8", {30'd0, taken_o, reg_we_o}, 32'd0);

    // R9 hold while idle
    issue(8'd17, 8'h02, 4'h0, 16'h0500, 16'h0009);
    @(negedge clk);
    cond_i = 8'd0; offset_i = 8'h40; pc_i = 16'hAAAA; reg_i = 16'h1111;
    @(negedge clk);
    chk("R9", {31'd0, valid_o}, 32'd0);
    chk("R9", {16'd0, target_o}, 32'h04FC);
    chk("R9", {15'd0, taken_o, reg_o}, 32'h10008);
    chk("R9", {31'd0, reg_we_o}, 32'd1);

    // R1 reset mid-run clears outputs
    rst_n = 1'b0;
    #1;
    chk("R1", {14'd0, valid_o, taken_o, target_o}, 32'd0);
    chk("R1", {15'd0, reg_we_o, reg_o}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule